// File: doc/BRIEF.md
# Timer-Synchronized Pulse Output Port

This block drives eight output pins from values that software writes into two data registers. The pins do not follow the registers directly. Each pin holds a latch, and the latch takes its register bit only in the cycle a timer underflow strobe arrives. Software can therefore stage a new pattern at any time, and the pattern reaches the pins at a fixed point in time set by the timers. Timer A1 is the main update event and timer A0 serves a second group.

The pins are split into two groups. In mode 0 the split is four high pins and four low pins. In mode 1 the split is six high pins and two low pins. A control register gives each group its own output enable, so a disabled group floats. The control register also holds an inversion option for the low nibble in mode 0, and a pulse-width gate. The gate ANDs latched data with PWM level inputs from other timers. It can use one common PWM source or a separate source for each pin pair.

The write bus is a single-cycle strobe with a 2-bit address. Address 0 is the control register, address 1 is data register 0 and address 2 is data register 1. Writes to address 3 are dropped.

Top module: `tspo_top`

## Requirements
- R1: After a synchronous active-low reset, every register and every pin latch is 0. That gives mode 0, PWM off, `pin_oe` = 0 and `pin_out` = 0.
- R2: A register write changes neither the pins nor the latches until a strobe arrives. A write to address 3 changes no state. Writes take effect at the clock edge where `wr_en` is high.
- R3: In mode 0, `a1_zero` loads data register 1 bits 3:0 into the high pin latches, and `a0_zero` loads data register 0 bits 3:0 into the low pin latches. `pin_out[7:4]` carries the high nibble and `pin_out[3:0]` the low nibble. A latch samples the register value held before the edge.
- R4: Data register 1 bit 4 selects mode 1. In mode 1, `a1_zero` loads `pin_out[7:2]` from data register 1 bits 3:0 and data register 0 bits 3:2. `a0_zero` loads only `pin_out[1:0]`, from data register 0 bits 1:0.
- R5: In mode 0, control bit 3 = 1 inverts `pin_out[3:0]` relative to the latches. In mode 1 control bit 3 has no effect.
- R6: In mode 0, `pin_out[7:4]` is the latch AND `pwm_a2` only when control bit 4 = 1, control bit 5 = 0 and data register 0 bit 5 = 1. Otherwise the high nibble shows its latch unchanged.
- R7: In mode 1 with control bit 4 = 1 and control bit 5 = 0, each pin pair is gated by `pwm_a2` when its enable bit is 1. Data register 0 bit 5 enables pins 3:2, bit 6 enables pins 5:4 and bit 7 enables pins 7:6. Pins 1:0 are never gated.
- R8: In mode 1 with control bits 4 and 5 both 1, the enabled pairs use separate sources: pins 7:6 use `pwm_a2`, pins 5:4 use `pwm_a3` and pins 3:2 use `pwm_a4`.
- R9: Control bit 6 enables the low group and bit 7 enables the high group. The low group is pins 3:0 in mode 0 and pins 1:0 in mode 1. A pin whose enable is 0 has `pin_oe` = 0 and `pin_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 data 0, 2 data 1 |
| wr_data | input | 8 | Write data |
| a0_zero | input | 1 | Timer A0 underflow strobe |
| a1_zero | input | 1 | Timer A1 underflow strobe |
| pwm_a2 | input | 1 | PWM level from timer A2 |
| pwm_a3 | input | 1 | PWM level from timer A3 |
| pwm_a4 | input | 1 | PWM level from timer A4 |
| pin_out | output | 8 | Pin values, bits 7:4 high nibble, 3:0 low nibble |
| pin_oe | output | 8 | Per-pin output enable, 0 = floating |

## Verification
Directed steps apply one strobe at a time in each mode. This shows which pins belong to which timer, and it catches a wrong 4+4 or 6+2 split. A write with no strobe, and a write to the unused address, confirm that data moves only on underflow. The PWM steps drive `pwm_a2`, `pwm_a3` and `pwm_a4` to unequal levels, so a per-pair source swapped with the common source shows up on the pins. A long random run then mixes writes, both strobes and PWM levels together, including writes in the same cycle as a strobe, and compares every cycle against a bench model.

// File: rtl/tspo_pkg.sv
// Shared definitions for the timer-synchronized pulse output port.
// Assumes an 8-bit write bus and two 4-pin nibbles.
package tspo_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int NIB_W    = 4;
    localparam int PIN_W    = 2 * NIB_W;
    localparam int NPAIR    = PIN_W / 2;
    localparam int GATED_W  = NPAIR - 1;

    localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DAT0 = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DAT1 = 2'd2;

    // Control register, stored from write bits 7:3.
    typedef struct packed {
        logic oe_hi;     // bit 7
        logic oe_lo;     // bit 6
        logic pwm_pair;  // bit 5
        logic pwm_on;    // bit 4
        logic invert;    // bit 3
    } ctl_t;
endpackage

// File: rtl/tspo_regs.sv
// Register file of the pulse output port: control, data 0 and data 1.
// Assumes single-cycle writes; unknown addresses are dropped.
module tspo_regs
    import tspo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctl_t              ctl_q,
    output logic [NIB_W-1:0]  d0_nib,
    output logic [GATED_W-1:0] d0_pwm_en,
    output logic [NIB_W-1:0]  d1_nib,
    output logic              mode1
);
    // Capture writes into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            d0_nib    <= '0;
            d0_pwm_en <= '0;
            d1_nib    <= '0;
            mode1     <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTL:  ctl_q <= ctl_t'(wr_data[DATA_W-1:DATA_W-5]);
                ADDR_DAT0: begin
                    d0_nib    <= wr_data[NIB_W-1:0];
                    d0_pwm_en <= wr_data[DATA_W-1:DATA_W-GATED_W];
                end
                ADDR_DAT1: begin
                    d1_nib <= wr_data[NIB_W-1:0];
                    mode1  <= wr_data[NIB_W];
                end
                default: ;
            endcase
        end
    end

    // R2: without a write strobe, no register moves.
    assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ctl_q) && $stable(d0_nib) && $stable(d1_nib) && $stable(mode1)));
endmodule

// File: rtl/tspo_latch.sv
// Pin latches: each pin takes its register bit on its timer's underflow.
// Assumes the mode bit selects which strobe serves pins 3:2.
module tspo_latch
    import tspo_pkg::*;
#(
    parameter int SPLIT = 2   // low pins always owned by timer A0 in both modes
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode1,
    input  logic             a0_zero,
    input  logic             a1_zero,
    input  logic [NIB_W-1:0] d0_nib,
    input  logic [NIB_W-1:0] d1_nib,
    output logic [NIB_W-1:0] lat_hi,
    output logic [NIB_W-1:0] lat_lo
);
    // High nibble always follows timer A1.
    always_ff @(posedge clk) begin
        if (!rst_n)       lat_hi <= '0;
        else if (a1_zero) lat_hi <= d1_nib;
    end

    for (genvar i = 0; i < NIB_W; i++) begin : g_lo
        logic take;
        if (i >= SPLIT) begin : g_moving
            assign take = mode1 ? a1_zero : a0_zero;
        end else begin : g_fixed
            assign take = a0_zero;
        end
        // Low-nibble pin loads on its selected strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)    lat_lo[i] <= 1'b0;
            else if (take) lat_lo[i] <= d0_nib[i];
        end
    end

    // R1: latches leave reset cleared.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (lat_hi == '0 && lat_lo == '0));
    // R3: in mode 0 an A1-only strobe leaves the low nibble alone.
    assert_mode0_a1_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode1 && a1_zero && !a0_zero) |=> $stable(lat_lo));
    // R4: in mode 1 an A0-only strobe touches only pins 1:0.
    assert_mode1_a0_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 && a0_zero && !a1_zero) |=> ($stable(lat_hi) && $stable(lat_lo[NIB_W-1:SPLIT])));
endmodule

// File: rtl/tspo_shape.sv
// Output shaping: polarity, PWM gating per pin pair and group enables.
// Assumes pair 0 (pins 1:0) is never gated; pairs 1..3 take enables 5..7.
module tspo_shape
    import tspo_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  ctl_t               ctl_q,
    input  logic               mode1,
    input  logic [GATED_W-1:0] d0_pwm_en,
    input  logic [NIB_W-1:0]   lat_hi,
    input  logic [NIB_W-1:0]   lat_lo,
    input  logic               pwm_a2,
    input  logic               pwm_a3,
    input  logic               pwm_a4,
    output logic [PIN_W-1:0]   pin_out,
    output logic [PIN_W-1:0]   pin_oe
);
    logic [PIN_W-1:0]   raw;
    logic [PIN_W-1:0]   shaped;
    logic [GATED_W-1:0] gate_on;
    logic [GATED_W-1:0] gate_src;
    logic               m0_gate;

    // Raw pin levels with optional low-nibble inversion in mode 0.
    always_comb begin
        raw = {lat_hi, lat_lo ^ {NIB_W{ctl_q.invert && !mode1}}};
    end

    // Pick gate enables and gate sources for pairs 1..3.
    always_comb begin
        m0_gate  = ctl_q.pwm_on && !ctl_q.pwm_pair && d0_pwm_en[0];
        gate_src = ctl_q.pwm_pair ? {pwm_a2, pwm_a3, pwm_a4} : {GATED_W{pwm_a2}};
        if (mode1) gate_on = ctl_q.pwm_on ? d0_pwm_en : '0;
        else       gate_on = {m0_gate, m0_gate, 1'b0};
    end

    assign shaped[1:0] = raw[1:0];
    for (genvar p = 1; p < NPAIR; p++) begin : g_pair
        assign shaped[2*p+1:2*p] = raw[2*p+1:2*p] & {2{!gate_on[p-1] || gate_src[p-1]}};
    end

    // Group enables follow the active pin split.
    always_comb begin
        if (mode1) pin_oe = {{(PIN_W-2){ctl_q.oe_hi}}, {2{ctl_q.oe_lo}}};
        else       pin_oe = {{NIB_W{ctl_q.oe_hi}}, {NIB_W{ctl_q.oe_lo}}};
        pin_out = shaped & pin_oe;
    end

    // R6: mode-0 gating with A2 low blanks the high nibble.
    assert_mode0_gate_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode1 && ctl_q.pwm_on && !ctl_q.pwm_pair && d0_pwm_en[0] && !pwm_a2)
        |-> pin_out[PIN_W-1:NIB_W] == '0);
    // R8: per-pair gating of pins 5:4 follows A3.
    assert_pair_a3_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 && ctl_q.pwm_on && ctl_q.pwm_pair && d0_pwm_en[1] && !pwm_a3)
        |-> pin_out[5:4] == 2'b00);
    // R9: in mode 1, pins 3:2 share the enable of the high group.
    assert_six_group_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode1 |-> (pin_oe[3:2] == pin_oe[7:6]));
    // R9: a disabled pin never shows a high level.
    assert_float_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);
endmodule

// File: rtl/tspo_top.sv
// Timer-synchronized pulse output port: registers, pin latches, shaping.
// Assumes underflow strobes and PWM levels are synchronous to clk.
module tspo_top
    import tspo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              a0_zero,
    input  logic              a1_zero,
    input  logic              pwm_a2,
    input  logic              pwm_a3,
    input  logic              pwm_a4,
    output logic [7:0]        pin_out,
    output logic [7:0]        pin_oe
);
    ctl_t               ctl_q;
    logic [NIB_W-1:0]   d0_nib;
    logic [NIB_W-1:0]   d1_nib;
    logic [GATED_W-1:0] d0_pwm_en;
    logic               mode1;
    logic [NIB_W-1:0]   lat_hi;
    logic [NIB_W-1:0]   lat_lo;

    tspo_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctl_q(ctl_q), .d0_nib(d0_nib), .d0_pwm_en(d0_pwm_en), .d1_nib(d1_nib), .mode1(mode1)
    );

    tspo_latch u_latch (
        .clk(clk), .rst_n(rst_n), .mode1(mode1), .a0_zero(a0_zero), .a1_zero(a1_zero),
        .d0_nib(d0_nib), .d1_nib(d1_nib), .lat_hi(lat_hi), .lat_lo(lat_lo)
    );

    tspo_shape u_shape (
        .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .mode1(mode1), .d0_pwm_en(d0_pwm_en),
        .lat_hi(lat_hi), .lat_lo(lat_lo), .pwm_a2(pwm_a2), .pwm_a3(pwm_a3), .pwm_a4(pwm_a4),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );
endmodule

// File: tb/tb_tspo_top.sv
// Self-checking bench: directed corners then seeded random traffic, against a bench model.
module tb_tspo_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       a0_zero = 1'b0, a1_zero = 1'b0;
    logic       pwm_a2 = 1'b0, pwm_a3 = 1'b0, pwm_a4 = 1'b0;
    logic [7:0] pin_out, pin_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench model state
    logic [7:0] m_ctl = '0, m_d0 = '0, m_d1 = '0;
    logic [3:0] m_lhi = '0, m_llo = '0;

    always #2 clk = ~clk;

    tspo_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .a0_zero(a0_zero), .a1_zero(a1_zero), .pwm_a2(pwm_a2), .pwm_a3(pwm_a3),
        .pwm_a4(pwm_a4), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [15:0] expect_pins(input logic [7:0] c, input logic [7:0] d0,
                                                input logic [7:0] d1, input logic [3:0] lh,
                                                input logic [3:0] ll, input logic p2,
                                                input logic p3, input logic p4);
        logic       m1;
        logic [3:0] h, l;
        logic [7:0] oe;
        logic       s76, s54, s32;
        m1 = d1[4];
        h  = lh;
        l  = ll ^ ((!m1 && c[3]) ? 4'hF : 4'h0);
        if (!m1) begin
            if (c[4] && !c[5] && d0[5] && !p2) h = 4'h0;
            oe = {{4{c[7]}}, {4{c[6]}}};
        end else begin
            s76 = p2;
            s54 = c[5] ? p3 : p2;
            s32 = c[5] ? p4 : p2;
            if (c[4] && d0[7] && !s76) h[3:2] = 2'b00;
            if (c[4] && d0[6] && !s54) h[1:0] = 2'b00;
            if (c[4] && d0[5] && !s32) l[3:2] = 2'b00;
            oe = {{6{c[7]}}, {2{c[6]}}};
        end
        return {oe, {h, l} & oe};
    endfunction

    task automatic check(input string tag);
        logic [15:0] e;
        e = expect_pins(m_ctl, m_d0, m_d1, m_lhi, m_llo, pwm_a2, pwm_a3, pwm_a4);
        checks++;
        if ({pin_oe, pin_out} !== e) begin
            failures++;
            $display("FAIL %s: oe/out actual %h/%h expected %h/%h", tag, pin_oe, pin_out,
                     e[15:8], e[7:0]);
        end
    endtask

    // One cycle: drive at negedge, update model at posedge, check at next negedge.
    task automatic step(input logic we, input logic [1:0] ad, input logic [7:0] dt,
                        input logic s0, input logic s1, input logic [2:0] pw, input string tag);
        logic m1;
        wr_en = we; wr_addr = ad; wr_data = dt;
        a0_zero = s0; a1_zero = s1;
        {pwm_a2, pwm_a3, pwm_a4} = pw;
        @(posedge clk);
        m1 = m_d1[4];
        if (s1) begin
            m_lhi = m_d1[3:0];
            if (m1) m_llo[3:2] = m_d0[3:2];
        end
        if (s0) begin
            m_llo[1:0] = m_d0[1:0];
            if (!m1) m_llo[3:2] = m_d0[3:2];
        end
        if (we) begin
            case (ad)
                2'd0: m_ctl = dt;
                2'd1: m_d0 = dt;
                2'd2: m_d1 = dt;
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0; a0_zero = 1'b0; a1_zero = 1'b0;
        check(tag);
    endtask

    task automatic wr(input logic [1:0] ad, input logic [7:0] dt, input string tag);
        step(1'b1, ad, dt, 1'b0, 1'b0, {pwm_a2, pwm_a3, pwm_a4}, tag);
    endtask

    task automatic strobe(input logic s0, input logic s1, input logic [2:0] pw, input string tag);
        step(1'b0, 2'd0, 8'h00, s0, s1, pw, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");
        // R2: writes without strobe leave pins unchanged
        wr(2'd0, 8'hC0, "R2");
        wr(2'd2, 8'h0A, "R2");
        wr(2'd1, 8'h05, "R2");
        if (pin_out !== 8'h00) begin failures++; $display("FAIL R2: actual %h expected 00", pin_out); end
        checks++;
        // R3: mode 0 strobes, one at a time
        strobe(1'b0, 1'b1, 3'b000, "R3");
        if (pin_out !== 8'hA0) begin failures++; $display("FAIL R3: actual %h expected a0", pin_out); end
        checks++;
        strobe(1'b1, 1'b0, 3'b000, "R3");
        if (pin_out !== 8'hA5) begin failures++; $display("FAIL R3: actual %h expected a5", pin_out); end
        checks++;
        // R2: address 3 is dropped
        wr(2'd3, 8'hFF, "R2");
        strobe(1'b1, 1'b1, 3'b000, "R2");
        // R5: inversion in mode 0
        wr(2'd0, 8'hC8, "R5");
        if (pin_out !== 8'hAA) begin failures++; $display("FAIL R5: actual %h expected aa", pin_out); end
        checks++;
        // R6: mode 0 PWM on A2, and no gating when pair bit set
        wr(2'd0, 8'hD0, "R6");
        wr(2'd1, 8'h25, "R6");
        strobe(1'b0, 1'b0, 3'b100, "R6");
        strobe(1'b0, 1'b0, 3'b011, "R6");
        wr(2'd0, 8'hF0, "R6");
        // R4: mode 1 grouping
        wr(2'd2, 8'h1F, "R4");
        wr(2'd1, 8'h0E, "R4");
        strobe(1'b1, 1'b0, 3'b111, "R4");
        strobe(1'b0, 1'b1, 3'b111, "R4");
        wr(2'd1, 8'h03, "R4");
        strobe(1'b0, 1'b1, 3'b111, "R4");
        strobe(1'b1, 1'b0, 3'b111, "R4");
        wr(2'd1, 8'h0F, "R4");
        strobe(1'b1, 1'b1, 3'b111, "R4");
        // R5: inversion ignored in mode 1
        wr(2'd0, 8'hC8, "R5");
        // R7: common gate in mode 1
        wr(2'd0, 8'hD0, "R7");
        wr(2'd1, 8'hEF, "R7");
        strobe(1'b0, 1'b0, 3'b011, "R7");
        strobe(1'b0, 1'b0, 3'b100, "R7");
        wr(2'd1, 8'h4F, "R7");
        strobe(1'b0, 1'b0, 3'b011, "R7");
        // R8: per-pair sources
        wr(2'd0, 8'hF0, "R8");
        wr(2'd1, 8'hEF, "R8");
        strobe(1'b0, 1'b0, 3'b011, "R8");
        strobe(1'b0, 1'b0, 3'b101, "R8");
        strobe(1'b0, 1'b0, 3'b110, "R8");
        strobe(1'b0, 1'b0, 3'b000, "R8");
        // R9: group enables in both modes
        wr(2'd0, 8'h40, "R9");
        wr(2'd0, 8'h80, "R9");
        wr(2'd2, 8'h0F, "R9");
        wr(2'd0, 8'h40, "R9");
        wr(2'd0, 8'h80, "R9");
        wr(2'd0, 8'h00, "R9");
        // Random mix
        for (int n = 0; n < 2000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] & r[1], r[3:2], r[11:4], r[12] & r[13], r[14] & r[15], r[18:16],
                 m_d1[4] ? "R4" : "R3");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule